// File: doc/BRIEF.md
# High-Speed Handshake Chirp Sequencer (Host Side)

This block runs the host half of the speed handshake during a bus reset that the host itself starts. When asked to reset the bus it drives SE0 and watches the two-bit line state for a device Chirp K. A Chirp K that lasts long enough is accepted. A fixed number of cycles after the bus leaves that K, the block starts a transmit command and drives alternating Chirp K and Chirp J levels. Each level is held for one programmed duration. The sequence keeps going until the reset period has run out, and it always stops at the end of a whole chirp. The block then puts the operating mode back to normal with high-speed terminations, so that packet traffic can begin.

If no acceptable device chirp arrives before the reset period expires, the block ends the reset after exactly that period and returns to normal mode with full-speed termination. Every duration is a cycle count set by a parameter. The defaults assume a 60 MHz clock: 10 ms of reset, a 2.5 µs minimum device K, a 10 µs response delay and 50 µs per host chirp. The line state is taken to be synchronous to the clock.

Top module: `hs_chirp_host_seq`

## Requirements
- R1: During and after synchronous reset the outputs are idle: se0_drive=0, tx_req=0, tx_chirp_k=0, opmode=2'b00, term_select=1. While idle, line_state has no effect.
- R2: A bus_reset_req seen at a clock edge while the block is idle or finished gives se0_drive=1, opmode=2'b10 and term_select=0 from that edge on.
- R3: If no device chirp is accepted, se0_drive stays high for exactly RESET_LEN_CYC cycles. The outputs then become opmode=2'b00, term_select=1, and tx_req is never raised.
- R4: A device Chirp K is line_state=2'b10 held for at least K_MIN_CYC consecutive edges while SE0 is driven. A shorter run is discarded, and the count restarts after any edge that sees a non-K value.
- R5: An accepted K counts once the first edge that sees line_state leave 2'b10 is no later than edge RESET_LEN_CYC after the request. From that edge, se0_drive stays high and tx_req rises exactly START_DLY_CYC edges later.
- R6: While tx_req is high, se0_drive is low. tx_chirp_k (1=K, 0=J) starts at 1 and toggles, and every level lasts exactly CHIRP_LEN_CYC cycles.
- R7: The chirp train ends at the first chirp boundary that lies at least RESET_LEN_CYC edges after the reset request, so the last chirp is always whole.
- R8: After the chirp train, the outputs are opmode=2'b00, term_select=0, se0_drive=0 and tx_req=0, and they stay that way until the next request.
- R9: A bus_reset_req that arrives while a reset or chirp sequence is in progress has no effect.
- R10: se0_drive and tx_req are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_req | input | 1 | Start a bus reset with speed handshake |
| line_state | input | 2 | Bus line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| se0_drive | output | 1 | Host drives SE0 on the bus |
| tx_req | output | 1 | No-PID transmit command active (chirp train) |
| tx_chirp_k | output | 1 | Chirp level while tx_req: 1 = K, 0 = J |
| opmode | output | 2 | Transceiver operating mode: 00 normal, 10 chirp (no stuffing or NRZI) |
| term_select | output | 1 | 1 = full-speed termination, 0 = high-speed termination |

## Verification
All outputs are registered from the next state, so a request seen at edge E0 shows up in the sample taken just after E0. Counted from there, SE0 covers samples 0 to RESET_LEN_CYC-1 when no chirp is accepted. When a K ends at edge je, the first tx_req sample is je+START_DLY_CYC and the finishing sample is the first je+START_DLY_CYC+m·CHIRP_LEN_CYC (m≥1) that is at least RESET_LEN_CYC. The bench drives line_state one edge ahead on the falling clock and samples every output on the falling clock. It compares each sample index with a value that a bench function computes from these formulas, so every cycle of every trial is checked where its result is due.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SE0,
    ST_GAP,
    ST_CHIRP,
    ST_DONE_FS,
    ST_DONE_HS
  } hcs_state_e;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_K   = 2'b10;

  localparam logic [1:0] OPM_NORMAL = 2'b00;
  localparam logic [1:0] OPM_CHIRP  = 2'b10;

  typedef struct packed {
    logic       se0;
    logic       tx;
    logic       lvl_k;
    logic [1:0] opmode;
    logic       term;
  } hcs_out_t;

  // Output pattern for each sequencer state
  function automatic hcs_out_t hcs_decode(hcs_state_e s, logic lvl);
    hcs_out_t o;
    o        = '0;
    o.opmode = OPM_NORMAL;
    o.term   = 1'b1;
    case (s)
      ST_SE0, ST_GAP: begin
        o.se0    = 1'b1;
        o.opmode = OPM_CHIRP;
        o.term   = 1'b0;
      end
      ST_CHIRP: begin
        o.tx     = 1'b1;
        o.lvl_k  = lvl;
        o.opmode = OPM_CHIRP;
        o.term   = 1'b0;
      end
      ST_DONE_HS: o.term = 1'b0;
      default: ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/hcs_counter.sv
// Saturating up-counter with synchronous clear
module hcs_counter #(
  parameter int unsigned W       = 4,
  parameter int unsigned MAX_VAL = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && (cnt != W'(MAX_VAL))) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/hcs_fsm.sv
module hcs_fsm
  import hcs_pkg::*;
#(
  parameter int unsigned START_DLY_CYC = 600,
  parameter int unsigned CHIRP_LEN_CYC = 3000,
  parameter int unsigned PH_W          = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_req,
  input  logic            k_seen,
  input  logic            k_ok,
  input  logic            rst_expired,
  input  logic [PH_W-1:0] ph_cnt,
  output hcs_state_e      state_q,
  output hcs_state_e      state_d,
  output logic            lvl_d,
  output logic            ph_clr
);

  logic lvl_q;
  logic ph_end;

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    ph_end  = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE_FS, ST_DONE_HS: begin
        if (start_req) state_d = ST_SE0;
      end
      ST_SE0: begin
        // a qualified K that just ended wins over expiry on the same edge
        if (!k_seen && k_ok)   state_d = ST_GAP;
        else if (rst_expired)  state_d = ST_DONE_FS;
      end
      ST_GAP: begin
        if (ph_cnt == PH_W'(START_DLY_CYC - 1)) begin
          state_d = ST_CHIRP;
          lvl_d   = 1'b1;
        end
      end
      ST_CHIRP: begin
        if (ph_cnt == PH_W'(CHIRP_LEN_CYC - 1)) begin
          ph_end = 1'b1;
          if (rst_expired) state_d = ST_DONE_HS;
          else             lvl_d   = ~lvl_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    ph_clr = ph_end || (state_d != state_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      lvl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
    end
  end

endmodule

// File: rtl/hs_chirp_host_seq.sv
module hs_chirp_host_seq
  import hcs_pkg::*;
#(
  parameter int unsigned RESET_LEN_CYC = 600000,
  parameter int unsigned CHIRP_LEN_CYC = 3000,
  parameter int unsigned K_MIN_CYC     = 150,
  parameter int unsigned START_DLY_CYC = 600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_reset_req,
  input  logic [1:0] line_state,
  output logic       se0_drive,
  output logic       tx_req,
  output logic       tx_chirp_k,
  output logic [1:0] opmode,
  output logic       term_select
);

  localparam int unsigned RST_MAX = RESET_LEN_CYC - 1;
  localparam int unsigned RST_W   = (RST_MAX < 1) ? 1 : $clog2(RST_MAX + 1);
  localparam int unsigned PH_MAX  =
    ((CHIRP_LEN_CYC > START_DLY_CYC) ? CHIRP_LEN_CYC : START_DLY_CYC) - 1;
  localparam int unsigned PH_W    = (PH_MAX < 1) ? 1 : $clog2(PH_MAX + 1);
  localparam int unsigned K_W     = $clog2(K_MIN_CYC + 1);

  hcs_state_e        state_q, state_d;
  logic              lvl_d, ph_clr;
  logic [RST_W-1:0]  rst_cnt;
  logic [PH_W-1:0]   ph_cnt;
  logic [K_W-1:0]    k_cnt;
  logic              k_seen, k_ok, rst_expired, rst_clr, k_clr;
  hcs_out_t          out_q;

  assign k_seen      = (line_state == LS_K);
  assign k_ok        = (k_cnt == K_W'(K_MIN_CYC));
  assign rst_expired = (rst_cnt == RST_W'(RST_MAX));
  assign rst_clr     = (state_q == ST_IDLE) || (state_q == ST_DONE_FS) ||
                       (state_q == ST_DONE_HS);
  assign k_clr       = (state_q != ST_SE0) || !k_seen;

  // reset-period timer, runs from the request edge
  hcs_counter #(.W(RST_W), .MAX_VAL(RST_MAX)) i_rst_tmr (
    .clk(clk), .rst(rst), .clr(rst_clr), .en(1'b1), .cnt(rst_cnt)
  );

  // consecutive device-K qualifier
  hcs_counter #(.W(K_W), .MAX_VAL(K_MIN_CYC)) i_k_qual (
    .clk(clk), .rst(rst), .clr(k_clr), .en(1'b1), .cnt(k_cnt)
  );

  // response-gap and per-chirp timer
  hcs_counter #(.W(PH_W), .MAX_VAL(PH_MAX)) i_ph_tmr (
    .clk(clk), .rst(rst), .clr(ph_clr), .en(1'b1), .cnt(ph_cnt)
  );

  hcs_fsm #(
    .START_DLY_CYC(START_DLY_CYC),
    .CHIRP_LEN_CYC(CHIRP_LEN_CYC),
    .PH_W(PH_W)
  ) i_fsm (
    .clk(clk), .rst(rst), .start_req(bus_reset_req),
    .k_seen(k_seen), .k_ok(k_ok), .rst_expired(rst_expired),
    .ph_cnt(ph_cnt), .state_q(state_q), .state_d(state_d),
    .lvl_d(lvl_d), .ph_clr(ph_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) out_q <= hcs_decode(ST_IDLE, 1'b0);
    else     out_q <= hcs_decode(state_d, lvl_d);
  end

  assign se0_drive   = out_q.se0;
  assign tx_req      = out_q.tx;
  assign tx_chirp_k  = out_q.lvl_k;
  assign opmode      = out_q.opmode;
  assign term_select = out_q.term;

endmodule

// File: rtl/hcs_chk.sv
module hcs_chk #(
  parameter int unsigned CHIRP_LEN_CYC = 3000,
  parameter int unsigned RUN_W         = $clog2(CHIRP_LEN_CYC + 2)
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_reset_req,
  input logic       se0_drive,
  input logic       tx_req,
  input logic       tx_chirp_k,
  input logic [1:0] opmode,
  input logic       term_select
);

  logic             prev_tx, prev_k;
  logic [RUN_W-1:0] run;

  // length of the chirp level run up to the previous cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_tx <= 1'b0;
      prev_k  <= 1'b0;
      run     <= '0;
    end else begin
      prev_tx <= tx_req;
      prev_k  <= tx_chirp_k;
      if (!tx_req)                           run <= '0;
      else if (!prev_tx || tx_chirp_k != prev_k) run <= RUN_W'(1);
      else if (run != {RUN_W{1'b1}})         run <= run + 1'b1;
    end
  end

  // R10
  excl_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !(se0_drive && tx_req));

  // R2
  start_se0_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_reset_req && opmode == 2'b00 && !se0_drive && !tx_req)
      |=> (se0_drive && opmode == 2'b10 && !term_select));

  // R6
  first_k_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_req) |-> tx_chirp_k);

  // R6
  chirp_len_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_req && prev_tx && tx_chirp_k != prev_k) |-> run == RUN_W'(CHIRP_LEN_CYC));

  // R7
  whole_chirp_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_req && prev_tx) |-> run == RUN_W'(CHIRP_LEN_CYC));

  // R8
  hs_finish_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_req) |-> (opmode == 2'b00 && !term_select && !se0_drive));

  // R3
  fs_finish_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(se0_drive) && !tx_req) |-> (opmode == 2'b00 && term_select));

  // R9
  se0_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(se0_drive) |-> ($past(opmode) == 2'b00 && !$past(tx_req)));

endmodule

bind hs_chirp_host_seq hcs_chk #(.CHIRP_LEN_CYC(CHIRP_LEN_CYC)) i_hcs_chk (
  .clk(clk), .rst(rst), .bus_reset_req(bus_reset_req),
  .se0_drive(se0_drive), .tx_req(tx_req), .tx_chirp_k(tx_chirp_k),
  .opmode(opmode), .term_select(term_select)
);

// File: tb/test_hs_chirp_host_seq.sv
module test_hs_chirp_host_seq;

  localparam int RL = 400;
  localparam int CL = 20;
  localparam int KM = 6;
  localparam int SD = 9;

  logic       clk = 1'b0;
  logic       rst;
  logic       bus_reset_req;
  logic [1:0] line_state;
  logic       se0_drive, tx_req, tx_chirp_k, term_select;
  logic [1:0] opmode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hs_chirp_host_seq #(
    .RESET_LEN_CYC(RL), .CHIRP_LEN_CYC(CL), .K_MIN_CYC(KM), .START_DLY_CYC(SD)
  ) i_hs_chirp_host_seq (
    .clk(clk), .rst(rst), .bus_reset_req(bus_reset_req), .line_state(line_state),
    .se0_drive(se0_drive), .tx_req(tx_req), .tx_chirp_k(tx_chirp_k),
    .opmode(opmode), .term_select(term_select)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [5:0] outs();
    return {se0_drive, tx_req, tx_chirp_k, opmode, term_select};
  endfunction

  // edge index whose sample first shows the finished state after a K ending at je
  function automatic int finish_idx(int je);
    int b = je + SD + CL;
    while (b < RL) b += CL;
    return b;
  endfunction

  // edge at which an accepted K ends, or -1 when none is accepted (R4, R5)
  function automatic int k_end_edge(int a, int la, int bb, int lb);
    if (la >= KM) return (a + la <= RL) ? a + la : -1;
    if (lb >= KM) return (bb + lb <= RL) ? bb + lb : -1;
    return -1;
  endfunction

  function automatic bit in_k(int j, int a, int la, int bb, int lb);
    return (j >= a && j < a + la) || (lb > 0 && j >= bb && j < bb + lb);
  endfunction

  // expected {se0, tx, k, opmode, term} at sample i of a trial
  function automatic logic [5:0] exp_vec(int i, int je);
    int s, b;
    logic k;
    if (je < 0) return (i < RL) ? 6'b100100 : 6'b000001;
    s = je + SD;
    b = finish_idx(je);
    if (i < s) return 6'b100100;
    if (i < b) begin
      k = (((i - s) / CL) % 2) == 0;
      return {1'b0, 1'b1, k, 2'b10, 1'b0};
    end
    return 6'b000000;
  endfunction

  task automatic run_trial(int a, int la, int bb, int lb, int extra, string base);
    int je, last, s, b;
    logic [5:0] got, exp;
    string tag;
    je   = k_end_edge(a, la, bb, lb);
    last = (je >= 0) ? finish_idx(je) : RL;
    s    = je + SD;
    b    = (je >= 0) ? finish_idx(je) : 0;
    @(negedge clk);
    bus_reset_req = 1'b1;
    line_state    = 2'b00;
    for (int i = 0; i <= last + 2; i++) begin
      @(negedge clk);
      got = outs();
      exp = exp_vec(i, je);
      if (i == 0)          tag = "R2";
      else if (je < 0)     tag = base;
      else if (i < s)      tag = "R5";
      else if (i < b)      tag = "R6";
      else if (i == b)     tag = "R7";
      else                 tag = "R8";
      if (extra > 0) tag = "R9";
      check(got === exp, tag, $sformatf("outputs at sample %0d", i), int'(got), int'(exp));
      check(!(se0_drive && tx_req), "R10", "se0 with tx", int'({se0_drive, tx_req}), 0);
      bus_reset_req = (extra > 0) && (i + 1 == extra);
      if (in_k(i + 1, a, la, bb, lb))     line_state = 2'b10;
      else if (je >= 0 && i + 1 > je)     line_state = 2'($urandom % 4);
      else                                line_state = 2'b00;
    end
    bus_reset_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout, expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int kind, a, la, bb, lb, extra;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    bus_reset_req = 1'b0;
    line_state = 2'b01;
    repeat (3) @(negedge clk);
    check(outs() === 6'b000001, "R1", "outputs in reset", int'(outs()), 1);
    rst = 1'b0;
    line_state = 2'b10;
    repeat (KM + 10) @(negedge clk);
    check(outs() === 6'b000001, "R1", "idle with K on line", int'(outs()), 1);
    line_state = 2'b01;
    @(negedge clk);

    // directed corners
    run_trial(0, 0, 0, 0, 0, "R3");                     // no chirp at all
    run_trial(5, KM, 0, 0, 0, "R4");                    // exact minimum K
    run_trial(5, KM - 1, 0, 0, 0, "R4");                // one short
    run_trial(5, KM - 1, 5 + KM, KM - 1, 0, "R4");      // split run
    run_trial(RL - KM, KM, 0, 0, 0, "R4");              // ends on expiry edge
    run_trial(RL - 3, 20, 0, 0, 0, "R4");               // still K at expiry
    run_trial(20, 10, 0, 0, 3, "R9");                   // request during SE0
    run_trial(20, 10, 0, 0, 30 + SD + 5, "R9");         // request during chirp
    run_trial(8, KM + 2, 0, 0, 0, "R5");

    // constrained random trials
    for (int t = 0; t < 30; t++) begin
      kind = $urandom % 4;
      a = 2 + $urandom % 60;
      la = 0; bb = 0; lb = 0;
      case (kind)
        1: la = KM + $urandom % 40;
        2: la = 1 + $urandom % (KM - 1);
        3: begin
          la = 1 + $urandom % (KM - 1);
          bb = a + la + 1 + $urandom % 5;
          lb = 1 + $urandom % (2 * KM);
        end
        default: la = 0;
      endcase
      extra = ($urandom % 3 == 0) ? 1 + $urandom % 300 : 0;
      run_trial(a, la, bb, lb, extra, (kind == 0) ? "R3" : "R4");
    end

    done = 1'b1;
    report();
    $finish;
  end

endmodule